// File: doc/BRIEF.md
# Dual-Channel DDR I/Q Transmit Bridge

This block sits between a baseband transmit datapath and two digital-to-analog converters whose sample input is one double-data-rate bus. The user logic supplies separate in-phase (I) and quadrature (Q) samples on parallel buses, one pair per transmit sample clock cycle. For each of two independent RF channels, the bridge registers the pair and sends it to the converter. I goes out while the sample clock is high and Q goes out while it is low.

With each data word the bridge drives a select strobe that tells the converter which component is on the bus. It also forwards a data clock that is built from a second input clock, shifted 90 degrees from the sample clock. The forwarded clock therefore changes state in the middle of each data half-period. All three outputs come from one behavioural DDR output register structure. This keeps their launch delays alike and lets the whole path be simulated without vendor primitives.

The transmit sample clock is an input of its own, so the transmit rate can differ from the rate of any receive logic. Both clocks are generated outside the block.

Top module: `iq_ddr_tx_bridge`

## Requirements
- R1: An I sample present at a channel's input at rising sample-clock edge k is driven on that channel's data bus for the whole high phase that follows rising edge k+1.
- R2: The Q sample captured at the same edge k is driven on the data bus for the low phase that immediately follows that high phase. Both halves of one output cycle come from the same sample pair.
- R3: The select output is 1 while I is on the data bus (sample clock high) and 0 while Q is on the bus (sample clock low).
- R4: Outside reset, the forwarded data clock is 1 while the 90-degree clock is high and 0 while it is low.
- R5: While the synchronous active-high reset is held, both data buses read zero and both select outputs read 0 in both clock phases. Both forwarded clocks stay at 0.
- R6: Channels A and B are independent. Each channel's data bus shows only its own I and Q inputs, with the same timing.
- R7: Every bit of a sample reaches the same bit position of the data bus unchanged. Bit 0 is the LSB, and all 12 bits pass for both all-ones and all-zeros words.
- R8: Asserting reset in the middle of a stream clears the data and select outputs from the first rising edge at which reset is sampled. This holds in both phases of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Transmit sample clock; I/Q inputs are captured on its rising edge |
| smp_clk_q90 | input | 1 | Copy of smp_clk delayed by 90 degrees, source of the forwarded clocks |
| rst | input | 1 | Synchronous active-high reset |
| cha_i | input | 12 | Channel A in-phase sample |
| cha_q | input | 12 | Channel A quadrature sample |
| chb_i | input | 12 | Channel B in-phase sample |
| chb_q | input | 12 | Channel B quadrature sample |
| cha_dac_d | output | 12 | Channel A DDR data bus (I high phase, Q low phase) |
| cha_dac_sel | output | 1 | Channel A I/Q select (1 = I on bus) |
| cha_dac_clk | output | 1 | Channel A forwarded data clock |
| chb_dac_d | output | 12 | Channel B DDR data bus |
| chb_dac_sel | output | 1 | Channel B I/Q select |
| chb_dac_clk | output | 1 | Channel B forwarded data clock |

## Verification
The bench drives I and Q with deliberately different values: full-scale against zero, walking ones, and ramps. A design that swaps the components, inverts the select, or takes Q from the next pair instead of the current one therefore produces a visible mismatch in a specific half-cycle.

Each word is sampled in the middle of its phase and compared against a one-cycle latency. A missing or extra pipeline stage shifts the whole stream, so it fails every comparison.

Channel B is driven with a pattern unrelated to channel A, and in one scenario it is held constant. This exposes a cross-wired or shared lane. A reset asserted during a stream must clear the very next cycle; logic that only resets one phase register leaves stale Q or I on the bus.

// File: rtl/iq_bridge_pkg.sv
`timescale 1ns/1ps
package iq_bridge_pkg;
  // default converter sample width
  localparam int unsigned SAMPLE_W_DFLT = 12;
  // number of transmit RF lanes served by the bridge
  localparam int unsigned NUM_LANES = 2;
  // constant words launched by the strobe/clock registers
  localparam logic PHASE_HI = 1'b1;
  localparam logic PHASE_LO = 1'b0;
endpackage

// File: rtl/ddr_out_reg.sv
`timescale 1ns/1ps
// Behavioural DDR output register. Both words are taken on the rising edge;
// the low-phase word is retimed to the falling edge so a pair stays together.
module ddr_out_reg #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_rise,
  input  logic [WIDTH-1:0] d_fall,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] rise_r;
  logic [WIDTH-1:0] fall_hold;
  logic [WIDTH-1:0] fall_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_r    <= '0;
      fall_hold <= '0;
    end else begin
      rise_r    <= d_rise;
      fall_hold <= d_fall;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) fall_r <= '0;
    else     fall_r <= fall_hold;
  end

  // output mux: high phase shows the rising word, low phase the falling word
  assign q = clk ? rise_r : fall_r;
endmodule

// File: rtl/iq_tx_lane.sv
`timescale 1ns/1ps
module iq_tx_lane
  import iq_bridge_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DFLT
) (
  input  logic                smp_clk,
  input  logic                smp_clk_q90,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] s_i,
  input  logic [SAMPLE_W-1:0] s_q,
  output logic [SAMPLE_W-1:0] dac_d,
  output logic                dac_sel,
  output logic                dac_clk
);
  logic [SAMPLE_W-1:0] i_cap;
  logic [SAMPLE_W-1:0] q_cap;

  // capture stage: both components of a pair on the same rising edge
  always_ff @(posedge smp_clk) begin
    if (rst) begin
      i_cap <= '0;
      q_cap <= '0;
    end else begin
      i_cap <= s_i;
      q_cap <= s_q;
    end
  end

  ddr_out_reg #(.WIDTH(SAMPLE_W)) u_data (
    .clk    (smp_clk),
    .rst    (rst),
    .d_rise (i_cap),
    .d_fall (q_cap),
    .q      (dac_d)
  );

  ddr_out_reg #(.WIDTH(1)) u_sel (
    .clk    (smp_clk),
    .rst    (rst),
    .d_rise (PHASE_HI),
    .d_fall (PHASE_LO),
    .q      (dac_sel)
  );

  ddr_out_reg #(.WIDTH(1)) u_fwd_clk (
    .clk    (smp_clk_q90),
    .rst    (rst),
    .d_rise (PHASE_HI),
    .d_fall (PHASE_LO),
    .q      (dac_clk)
  );

  // values seen at an edge are those of the phase that just ended
  AST_I_IN_HIGH_PHASE: assert property (@(negedge smp_clk) disable iff (rst)
    !$past(rst) |-> dac_d == $past(i_cap));                       // R1
  AST_Q_IN_LOW_PHASE: assert property (@(posedge smp_clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> dac_d == $past(q_cap));   // R2
  AST_SEL_HIGH_WITH_I: assert property (@(negedge smp_clk) disable iff (rst)
    !$past(rst) |-> dac_sel);                                     // R3
  AST_SEL_LOW_WITH_Q: assert property (@(posedge smp_clk) disable iff (rst)
    !$past(rst) |-> !dac_sel);                                    // R3
  AST_FWD_CLK_HIGH: assert property (@(negedge smp_clk_q90) disable iff (rst)
    !$past(rst) |-> dac_clk);                                     // R4
  AST_FWD_CLK_LOW: assert property (@(posedge smp_clk_q90) disable iff (rst)
    !$past(rst) |-> !dac_clk);                                    // R4
endmodule

// File: rtl/iq_ddr_tx_bridge.sv
`timescale 1ns/1ps
module iq_ddr_tx_bridge
  import iq_bridge_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DFLT
) (
  input  logic                smp_clk,
  input  logic                smp_clk_q90,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] cha_i,
  input  logic [SAMPLE_W-1:0] cha_q,
  input  logic [SAMPLE_W-1:0] chb_i,
  input  logic [SAMPLE_W-1:0] chb_q,
  output logic [SAMPLE_W-1:0] cha_dac_d,
  output logic                cha_dac_sel,
  output logic                cha_dac_clk,
  output logic [SAMPLE_W-1:0] chb_dac_d,
  output logic                chb_dac_sel,
  output logic                chb_dac_clk
);
  logic [NUM_LANES-1:0][SAMPLE_W-1:0] lane_i, lane_q, lane_d;
  logic [NUM_LANES-1:0]               lane_sel, lane_clk;

  assign lane_i[0] = cha_i;
  assign lane_q[0] = cha_q;
  assign lane_i[1] = chb_i;
  assign lane_q[1] = chb_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    iq_tx_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .smp_clk     (smp_clk),
      .smp_clk_q90 (smp_clk_q90),
      .rst         (rst),
      .s_i         (lane_i[g]),
      .s_q         (lane_q[g]),
      .dac_d       (lane_d[g]),
      .dac_sel     (lane_sel[g]),
      .dac_clk     (lane_clk[g])
    );
  end

  assign cha_dac_d   = lane_d[0];
  assign cha_dac_sel = lane_sel[0];
  assign cha_dac_clk = lane_clk[0];
  assign chb_dac_d   = lane_d[1];
  assign chb_dac_sel = lane_sel[1];
  assign chb_dac_clk = lane_clk[1];

  // both lanes share one sample clock, so their strobes must agree
  AST_LANE_SEL_ALIGNED: assert property (@(negedge smp_clk) disable iff (rst)
    !$past(rst) |-> (cha_dac_sel == chb_dac_sel));               // R6
endmodule

// File: tb/iq_ddr_tx_bridge_tb_top.sv
`timescale 1ns/1ps
module iq_ddr_tx_bridge_tb_top;
  localparam int W = 12;

  logic smp_clk = 1'b0;
  logic smp_clk_q90 = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] cha_i = '0, cha_q = '0, chb_i = '0, chb_q = '0;
  logic [W-1:0] cha_dac_d, chb_dac_d;
  logic cha_dac_sel, cha_dac_clk, chb_dac_sel, chb_dac_clk;

  int n_checks = 0;
  int n_fails  = 0;

  logic [W-1:0] pa_i [16];
  logic [W-1:0] pa_q [16];
  logic [W-1:0] pb_i [16];
  logic [W-1:0] pb_q [16];

  // 250 MHz: 4 ns period, the second clock trails by a quarter period
  always #2 smp_clk = ~smp_clk;
  initial begin
    #1;
    forever #2 smp_clk_q90 = ~smp_clk_q90;
  end

  iq_ddr_tx_bridge #(.SAMPLE_W(W)) dut_i (
    .smp_clk(smp_clk), .smp_clk_q90(smp_clk_q90), .rst(rst),
    .cha_i(cha_i), .cha_q(cha_q), .chb_i(chb_i), .chb_q(chb_q),
    .cha_dac_d(cha_dac_d), .cha_dac_sel(cha_dac_sel), .cha_dac_clk(cha_dac_clk),
    .chb_dac_d(chb_dac_d), .chb_dac_sel(chb_dac_sel), .chb_dac_clk(chb_dac_clk)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic expect_cleared(input string req);
    check(cha_dac_d == '0, req, "A data cleared", cha_dac_d, '0);
    check(chb_dac_d == '0, req, "B data cleared", chb_dac_d, '0);
    check(!cha_dac_sel && !chb_dac_sel, req, "select low",
          {10'd0, cha_dac_sel, chb_dac_sel}, '0);
  endtask

  // pair m is driven at posedge m + 2.5 ns and appears after posedge m + 2
  task automatic run_stream(input string tag, input int len);
    for (int m = 0; m < len + 2; m++) begin
      @(posedge smp_clk);
      #1.5;
      if (m >= 2) begin
        check(cha_dac_d == pa_i[m-2], "R1", {tag, " A I"}, cha_dac_d, pa_i[m-2]);
        check(chb_dac_d == pb_i[m-2], "R6", {tag, " B I"}, chb_dac_d, pb_i[m-2]);
        check(cha_dac_sel && chb_dac_sel, "R3", {tag, " sel on I"},
              {10'd0, cha_dac_sel, chb_dac_sel}, 12'h003);
        check(cha_dac_clk && chb_dac_clk, "R4", {tag, " fwd clk high"},
              {10'd0, cha_dac_clk, chb_dac_clk}, 12'h003);
      end
      #1;
      if (m < len) begin
        cha_i = pa_i[m]; cha_q = pa_q[m];
        chb_i = pb_i[m]; chb_q = pb_q[m];
      end
      #1;
      if (m >= 2) begin
        check(cha_dac_d == pa_q[m-2], "R2", {tag, " A Q"}, cha_dac_d, pa_q[m-2]);
        check(chb_dac_d == pb_q[m-2], "R6", {tag, " B Q"}, chb_dac_d, pb_q[m-2]);
        check(!cha_dac_sel && !chb_dac_sel, "R3", {tag, " sel on Q"},
              {10'd0, cha_dac_sel, chb_dac_sel}, 12'h000);
        check(!cha_dac_clk && !chb_dac_clk, "R4", {tag, " fwd clk low"},
              {10'd0, cha_dac_clk, chb_dac_clk}, 12'h000);
      end
    end
  endtask

  task automatic t_reset_state;
    for (int c = 0; c < 3; c++) begin
      @(posedge smp_clk);
      #1.5;
      expect_cleared("R5");
      check(!cha_dac_clk && !chb_dac_clk, "R5", "fwd clk held low",
            {10'd0, cha_dac_clk, chb_dac_clk}, '0);
      #2;
      expect_cleared("R5");
    end
    @(negedge smp_clk);
    #0.5;
    rst = 1'b0;
  endtask

  task automatic t_ramp;
    for (int k = 0; k < 16; k++) begin
      pa_i[k] = W'(k * 37 + 5);
      pa_q[k] = W'(12'hFFF - k * 53);
      pb_i[k] = W'(k * 211 + 9);
      pb_q[k] = W'(k * 7);
    end
    run_stream("ramp R1 R2", 16);
  endtask

  task automatic t_extremes;
    for (int k = 0; k < 8; k++) begin
      pa_i[k] = (k % 2 == 0) ? 12'hFFF : 12'h000;
      pa_q[k] = (k % 2 == 0) ? 12'h000 : 12'hFFF;
      pb_i[k] = ~pa_i[k];
      pb_q[k] = ~pa_q[k];
    end
    run_stream("extremes R7", 8);
  endtask

  task automatic t_walking_one;
    for (int k = 0; k < 12; k++) begin
      pa_i[k] = W'(1) << k;
      pa_q[k] = W'(1) << (11 - k);
      pb_i[k] = ~(W'(1) << k);
      pb_q[k] = ~(W'(1) << (11 - k));
    end
    run_stream("walking R7", 12);
  endtask

  task automatic t_lane_isolation;
    for (int k = 0; k < 10; k++) begin
      pa_i[k] = W'(k * 409 + 3);
      pa_q[k] = W'(k * 97 + 1000);
      pb_i[k] = 12'h5A5;
      pb_q[k] = 12'hA5A;
    end
    run_stream("isolation R6", 10);
  endtask

  task automatic t_mid_reset;
    cha_i = 12'hABC; cha_q = 12'h123; chb_i = 12'h777; chb_q = 12'h888;
    repeat (3) @(posedge smp_clk);
    #2.5;
    rst = 1'b1;
    @(posedge smp_clk);
    #1.5;
    expect_cleared("R8");
    #2;
    expect_cleared("R8");
    @(negedge smp_clk);
    #0.5;
    rst = 1'b0;
  endtask

  initial begin
    #800000;
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_ramp();
    t_extremes();
    t_walking_one();
    t_lane_isolation();
    t_mid_reset();
    t_ramp();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule